// File: doc/BRIEF.md
# SPI Controller Register Front End

This block is the bus-facing register file of a serial peripheral interface controller. It holds seven 16-bit registers: control, slave-select flags, status, transmit buffer, receive buffer, clock divisor and receive shadow. It checks the width and the offset of every bus access, applies reset values, and updates the status flags. Software clears status flags by writing ones to them. Buffer accesses also change status flags, depending on the enable bit and the transfer-initiation mode held in control. The shift engine, clock generation, DMA and interrupt routing sit outside this block. They observe the status word on a dedicated output.

The bus has independent write and read channels. Each channel has its own address, size code and strobe, so one write and one read can happen in the same cycle. Read data and both error responses are registered and appear one cycle after the strobe.

Top module: `spi_reg_front`

## Requirements
- R1: After reset, control reads 0x0400, flags 0xFF00, status 0x0001, and every other register reads 0x0000.
- R2: The registers sit at byte offsets 0x00 control, 0x04 flags, 0x08 status, 0x0C transmit buffer, 0x10 receive buffer, 0x14 divisor and 0x18 shadow. Control, flags, divisor, shadow and both buffers store written data and read it back unchanged.
- R3: Only size code 1 (two bytes) is legal. Size codes 0, 2 and 3 return error code 1, change no register and cause no side effect. This check wins over the unmapped-offset check.
- R4: An offset of 0x1C or above, or one that is not a multiple of 4, returns error code 2, changes no register, causes no side effect and reads as 0x0000.
- R5: Writing status clears bit 0 (transfer complete), bit 3 (transmit full) and bit 5 (receive full) wherever the write data has a one. Every other status bit ignores writes.
- R6: A transmit buffer write while control bit 14 (enable) is 1 and control[1:0] is 1 (transmit-initiated) sets status bit 5 and clears bit 3. With any other control setting, the write leaves status unchanged.
- R7: A receive buffer read returns the buffer contents. When enable is 1 and control[1:0] is 0 (receive-initiated), the read clears status bits 5 and 3 at the same clock edge. Reads of any other register have no side effect.
- R8: Read data and read error code are valid one cycle after the read strobe. Read data is 0x0000 in cycles with no valid read. The write error code is valid one cycle after the write strobe. Code 0 means no error.
- R9: A read in the same cycle as a write returns the value held before that write. Side-effect conditions use the control value held before a same-cycle control write. When a side effect and a write-one-to-clear touch the same flag, the side effect wins.
- R10: The status output always equals the current status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_size | input | 2 | Write size code (1 = two bytes) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 5 | Read byte offset |
| rd_size | input | 2 | Read size code (1 = two bytes) |
| rd_data | output | 16 | Registered read data |
| rd_err | output | 2 | Registered read error code (0 ok, 1 size, 2 unmapped) |
| wr_err | output | 2 | Registered write error code (0 ok, 1 size, 2 unmapped) |
| stat_o | output | 16 | Current status word |

## Verification
Three things can land on the same clock edge: a status write that clears flags, a buffer access whose side effect changes flags, and a control write that changes the mode. The bench provokes these together. It writes status while reading the receive buffer in receive-initiated mode. It writes control in the same cycle as a receive buffer read, and the read must be judged under the old mode. It reads status in the same cycle as a clearing write, and the read must show the pre-clear word. In each case the bench checks the returned data, the error codes and the status output in the cycle after the edge.

// File: rtl/spi_rf_pkg.sv
// Package: shared constants for the SPI register front end.
// Assumes 16-bit registers on a 4-byte stride and a 2-bit size code.
package spi_rf_pkg;
    localparam int DATA_W   = 16;
    localparam int NREG     = 7;
    localparam int IDX_CTL  = 0;
    localparam int IDX_FLG  = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_TBUF = 3;
    localparam int IDX_RBUF = 4;
    localparam int IDX_DIV  = 5;
    localparam int IDX_SHAD = 6;

    localparam logic [1:0] SIZE_HALF = 2'd1;

    localparam int BIT_DONE = 0;
    localparam int BIT_TXF  = 3;
    localparam int BIT_RXF  = 5;
    localparam int BIT_EN   = 14;
    localparam logic [1:0] MODE_RX = 2'd0;
    localparam logic [1:0] MODE_TX = 2'd1;

    localparam logic [DATA_W-1:0] FLAG_MASK =
        DATA_W'((1 << BIT_DONE) | (1 << BIT_TXF) | (1 << BIT_RXF));

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_SIZE  = 2'd1,
        ERR_UNMAP = 2'd2
    } err_e;

    // Reset value of each register slot.
    function automatic logic [DATA_W-1:0] rst_val(input int idx);
        case (idx)
            IDX_CTL:  return 16'h0400;
            IDX_FLG:  return 16'hFF00;
            IDX_STAT: return 16'h0001;
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/spi_rf_decode.sv
// Module: access checker and offset decoder for one bus channel.
// Assumes byte offsets; a legal access is two bytes wide and lands on a
// multiple of 4 below NREG*4. The size error outranks the unmapped error.
module spi_rf_decode
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [NREG-1:0]   hit,
    output err_e              code
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    // Classify the access and raise at most one hit line.
    always_comb begin
        hit  = '0;
        code = ERR_NONE;
        if (strobe) begin
            if (size != SIZE_HALF) begin
                code = ERR_SIZE;
            end else if ((addr[1:0] != 2'b00) || (int'(idx) >= NREG)) begin
                code = ERR_UNMAP;
            end else begin
                hit[idx] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_rf_bank.sv
// Module: plain read/write registers for every slot except status.
// Assumes at most one write enable is high per cycle; the status slot
// is kept elsewhere and reads back as zero here.
module spi_rf_bank
    import spi_rf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREG-1:0]              we,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NREG-1:0][DATA_W-1:0]  q
);
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g == IDX_STAT) begin : g_hole
            assign q[g] = '0;
        end else begin : g_reg
            // Load the slot on its own write strobe, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n)      q[g] <= rst_val(g);
                else if (we[g])  q[g] <= wdata;
            end

            a_r4_hold_without_write: assert property (@(posedge clk)
                disable iff (!rst_n) !we[g] |=> $stable(q[g]));
            a_r2_store_on_write: assert property (@(posedge clk)
                disable iff (!rst_n) we[g] |=> q[g] == $past(wdata));
        end
    end
endmodule

// File: rtl/spi_rf_status.sv
// Module: status word with write-one-to-clear flags and buffer side effects.
// Assumes tx_evt and rx_evt are never high together. A side effect
// overrides a same-cycle clear on the flag it touches.
module spi_rf_status
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_evt,
    input  logic              rx_evt,
    output logic [DATA_W-1:0] stat
);
    logic [DATA_W-1:0] nxt;

    // Apply the clear mask first, then let the side effects override it.
    always_comb begin
        nxt = stat;
        if (wr_hit) nxt = nxt & ~(wdata & FLAG_MASK);
        if (tx_evt) begin
            nxt[BIT_RXF] = 1'b1;
            nxt[BIT_TXF] = 1'b0;
        end
        if (rx_evt) begin
            nxt[BIT_RXF] = 1'b0;
            nxt[BIT_TXF] = 1'b0;
        end
    end

    // Hold the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= rst_val(IDX_STAT);
        else        stat <= nxt;
    end

    a_r6_tx_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt |=> stat[BIT_RXF] && !stat[BIT_TXF]);
    a_r7_rx_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> !stat[BIT_RXF] && !stat[BIT_TXF]);
    a_r5_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata[BIT_DONE]) |=> !stat[BIT_DONE]);
    a_r5_other_bits_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat & ~FLAG_MASK) == ($past(stat) & ~FLAG_MASK));
    a_r7_no_event_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !tx_evt && !rx_evt) |=> $stable(stat));
endmodule

// File: rtl/spi_reg_front.sv
// Module: top of the SPI register front end. Joins the two channel
// decoders, the plain bank and the status word, derives the side-effect
// events from the control value held before the edge, and registers
// read data and error codes. Assumes separate read and write channels.
module spi_reg_front
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_size,
    input  logic [15:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_size,
    output logic [15:0]       rd_data,
    output logic [1:0]        rd_err,
    output logic [1:0]        wr_err,
    output logic [15:0]       stat_o
);
    logic [NREG-1:0]             w_hit, r_hit;
    err_e                        w_code, r_code;
    logic [NREG-1:0][DATA_W-1:0] bank_q;
    logic [DATA_W-1:0]           stat;
    logic [DATA_W-1:0]           ctl;
    logic                        ctl_on;
    logic                        tx_evt, rx_evt;
    logic [DATA_W-1:0]           rd_mux;

    spi_rf_decode #(.ADDR_W(ADDR_W)) u_wdec (
        .strobe(wr_en), .addr(wr_addr), .size(wr_size),
        .hit(w_hit), .code(w_code));

    spi_rf_decode #(.ADDR_W(ADDR_W)) u_rdec (
        .strobe(rd_en), .addr(rd_addr), .size(rd_size),
        .hit(r_hit), .code(r_code));

    spi_rf_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(w_hit), .wdata(wr_data), .q(bank_q));

    assign ctl    = bank_q[IDX_CTL];
    assign ctl_on = ctl[BIT_EN];

    // Side effects judged on the control value held before this edge.
    assign tx_evt = w_hit[IDX_TBUF] && ctl_on && (ctl[1:0] == MODE_TX);
    assign rx_evt = r_hit[IDX_RBUF] && ctl_on && (ctl[1:0] == MODE_RX);

    spi_rf_status u_stat (
        .clk(clk), .rst_n(rst_n), .wr_hit(w_hit[IDX_STAT]), .wdata(wr_data),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .stat(stat));

    // Gather the selected register; no hit leaves zero.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++) begin
            if (r_hit[i]) rd_mux = rd_mux | ((i == IDX_STAT) ? stat : bank_q[i]);
        end
    end

    // Register read data and both error responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_err  <= ERR_NONE;
            wr_err  <= ERR_NONE;
        end else begin
            rd_data <= rd_mux;
            rd_err  <= r_code;
            wr_err  <= w_code;
        end
    end

    assign stat_o = stat;

    a_r3_size_first: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size != SIZE_HALF) |=> wr_err == ERR_SIZE);
    a_r3_read_size: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_size != SIZE_HALF) |=> rd_err == ERR_SIZE && rd_data == '0);
    a_r8_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0 && rd_err == ERR_NONE);
    a_r4_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SIZE_HALF && int'(wr_addr) >= 4 * NREG && !rd_en)
        |=> $stable(stat));
    a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_evt && rx_evt));
endmodule

// File: tb/sim_spi_reg_front.sv
module sim_spi_reg_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr = '0;
    logic [1:0]  wr_size = 2'd1, rd_size = 2'd1;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data, stat_o;
    logic [1:0]  rd_err, wr_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    spi_reg_front u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_size(wr_size), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_size(rd_size), .rd_data(rd_data), .rd_err(rd_err), .wr_err(wr_err),
        .stat_o(stat_o));

    typedef struct packed {
        logic        w;
        logic [4:0]  wa;
        logic [1:0]  ws;
        logic [15:0] wd;
        logic        r;
        logic [4:0]  ra;
        logic [1:0]  rs;
        logic [15:0] erd;
        logic [1:0]  ere;
        logic [1:0]  ewe;
        logic [15:0] est;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        // R1 reset values
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h00,2'd1, 16'h0400,2'd0,2'd0,16'h0001, 4'd1},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h04,2'd1, 16'hFF00,2'd0,2'd0,16'h0001, 4'd1},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h08,2'd1, 16'h0001,2'd0,2'd0,16'h0001, 4'd1},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h14,2'd1, 16'h0000,2'd0,2'd0,16'h0001, 4'd1},
        // R2 plain storage
        '{1'b1,5'h14,2'd1,16'h1234, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0001, 4'd2},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h14,2'd1, 16'h1234,2'd0,2'd0,16'h0001, 4'd2},
        // R9 read in write cycle returns old value
        '{1'b1,5'h18,2'd1,16'hA5A5, 1'b1,5'h18,2'd1, 16'h0000,2'd0,2'd0,16'h0001, 4'd9},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h18,2'd1, 16'hA5A5,2'd0,2'd0,16'h0001, 4'd2},
        // R6 disabled: transmit write stores but leaves status
        '{1'b1,5'h0C,2'd1,16'h00FF, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0001, 4'd6},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h0C,2'd1, 16'h00FF,2'd0,2'd0,16'h0001, 4'd2},
        '{1'b1,5'h00,2'd1,16'h4001, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0001, 4'd2},
        // R6 enabled, transmit-initiated
        '{1'b1,5'h0C,2'd1,16'h0055, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0021, 4'd6},
        // R5 clear bit 0, then ones on non-flag bits ignored
        '{1'b1,5'h08,2'd1,16'h0001, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0020, 4'd5},
        '{1'b1,5'h08,2'd1,16'hFFDF, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0020, 4'd5},
        // R7 receive read in transmit mode: no side effect
        '{1'b1,5'h10,2'd1,16'hBEEF, 1'b1,5'h10,2'd1, 16'h0000,2'd0,2'd0,16'h0020, 4'd7},
        // R9 control write same cycle as receive read: old mode used
        '{1'b1,5'h00,2'd1,16'h4000, 1'b1,5'h10,2'd1, 16'hBEEF,2'd0,2'd0,16'h0020, 4'd9},
        // R7 receive-initiated read clears flags
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h10,2'd1, 16'hBEEF,2'd0,2'd0,16'h0000, 4'd7},
        // R6 transmit write in receive mode: no side effect
        '{1'b1,5'h0C,2'd1,16'h1111, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0000, 4'd6},
        '{1'b1,5'h00,2'd1,16'h4001, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0000, 4'd2},
        '{1'b1,5'h0C,2'd1,16'h2222, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0020, 4'd6},
        // R9 status read during clearing write shows pre-clear word
        '{1'b1,5'h08,2'd1,16'h0020, 1'b1,5'h08,2'd1, 16'h0020,2'd0,2'd0,16'h0000, 4'd9},
        // R3 size errors, priority over unmapped
        '{1'b1,5'h14,2'd2,16'h0000, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd1,16'h0000, 4'd3},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h14,2'd0, 16'h0000,2'd1,2'd0,16'h0000, 4'd3},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h14,2'd1, 16'h1234,2'd0,2'd0,16'h0000, 4'd3},
        '{1'b1,5'h1E,2'd0,16'h0000, 1'b1,5'h1C,2'd3, 16'h0000,2'd1,2'd1,16'h0000, 4'd3},
        // R4 unmapped offsets
        '{1'b1,5'h1C,2'd1,16'hFFFF, 1'b1,5'h06,2'd1, 16'h0000,2'd2,2'd2,16'h0000, 4'd4},
        '{1'b1,5'h16,2'd1,16'h9999, 1'b1,5'h1C,2'd1, 16'h0000,2'd2,2'd2,16'h0000, 4'd4},
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h14,2'd1, 16'h1234,2'd0,2'd0,16'h0000, 4'd4},
        // R3 erroneous receive read in receive mode: no side effect
        '{1'b1,5'h0C,2'd1,16'h3333, 1'b0,5'h00,2'd1, 16'h0000,2'd0,2'd0,16'h0020, 4'd6},
        '{1'b1,5'h00,2'd1,16'h4000, 1'b1,5'h10,2'd2, 16'h0000,2'd1,2'd0,16'h0020, 4'd3},
        // R9 clearing write and receive-read clear in one cycle
        '{1'b1,5'h08,2'd1,16'h0020, 1'b1,5'h10,2'd1, 16'hBEEF,2'd0,2'd0,16'h0000, 4'd9},
        // R8 idle cycle reads zero
        '{1'b0,5'h00,2'd1,16'h0000, 1'b0,5'h10,2'd1, 16'h0000,2'd0,2'd0,16'h0000, 4'd8},
        // R10 status output follows register after a reread
        '{1'b0,5'h00,2'd1,16'h0000, 1'b1,5'h08,2'd1, 16'h0000,2'd0,2'd0,16'h0000, 4'd10}
    };

    task automatic check(input string what, input int req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog: actual %0d expected below 20000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Vector walk: drive at a falling edge, judge at the next one.
        for (int i = 0; i < NV; i++) begin
            wr_en = TBL[i].w;  wr_addr = TBL[i].wa; wr_size = TBL[i].ws;
            wr_data = TBL[i].wd;
            rd_en = TBL[i].r;  rd_addr = TBL[i].ra; rd_size = TBL[i].rs;
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            check("read data", int'(TBL[i].req), rd_data, TBL[i].erd);
            check("read error", int'(TBL[i].req), {14'd0, rd_err}, {14'd0, TBL[i].ere});
            check("write error", int'(TBL[i].req), {14'd0, wr_err}, {14'd0, TBL[i].ewe});
            check("status", int'(TBL[i].req), stat_o, TBL[i].est);
        end

        // R1: reset during a write restores reset values and drops the write
        wr_en = 1'b1; wr_addr = 5'h04; wr_size = 2'd1; wr_data = 16'h0000;
        rst_n = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        check("status after reset", 1, stat_o, 16'h0001);
        check("read data after reset", 1, rd_data, 16'h0000);
        rst_n = 1'b1;
        rd_en = 1'b1; rd_addr = 5'h04; rd_size = 2'd1;
        @(negedge clk);
        rd_en = 1'b0;
        check("flags after reset", 1, rd_data, 16'hFF00);
        rd_en = 1'b1; rd_addr = 5'h18;
        @(negedge clk);
        rd_en = 1'b0;
        check("shadow after reset", 1, rd_data, 16'h0000);

        // R7: reset control is disabled, so a receive read leaves status
        rd_en = 1'b1; rd_addr = 5'h10;
        @(negedge clk);
        rd_en = 1'b0;
        check("disabled receive read", 7, stat_o, 16'h0001);

        // R10: status output equals a status read
        rd_en = 1'b1; rd_addr = 5'h08;
        @(negedge clk);
        rd_en = 1'b0;
        check("status port vs read", 10, stat_o, rd_data);

        finish_run();
    end
endmodule